// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical memory access into a physical address. A logical access has two parts: a segment selector and an offset within that segment. The unit holds one descriptor for each of four segments: code, stack, data and extra. Each descriptor has a base address, a size bound and a loaded flag. Software or a control agent fills the descriptors through a simple write port.

On each request the unit reads the descriptor for the selected segment. It compares the offset with the segment size and adds the offset to the base. One cycle later it returns a response. The response either carries the physical address with a memory request strobe, or it raises an access fault with a cause code and drives no strobe.

The bound check compares the offset with the size, not the sum with a limit. An access past the end of its segment therefore always faults. It can never wrap into another part of memory.

Top module: `seg_xlat`

## Requirements
- R1: After reset, `rsp_valid_o`, `mem_req_o` and `fault_o` are low and every descriptor is unloaded.
- R2: `rsp_valid_o` is high in exactly the cycle after a cycle in which `req_i` was high, and low otherwise.
- R3: For a loaded segment with `off_i < size`, the response has `mem_req_o`=1, `fault_o`=0 and cause NONE (2'd0). It also has `paddr_o` = (base + offset) mod 2^PA_W.
- R4: For a loaded segment with `off_i >= size`, the response has `fault_o`=1, cause BOUND (2'd2), `mem_req_o`=0 and `paddr_o`=0.
- R5: For an unloaded segment, the response has `fault_o`=1, cause UNLOADED (2'd1), `mem_req_o`=0 and `paddr_o`=0, whatever the offset. UNLOADED takes priority over BOUND.
- R6: A segment of size 0 faults at every offset. A segment of size 2^OFF_W accepts every offset.
- R7: A write with `cfg_we_i`=1 and `cfg_load_i`=1 loads the base and size into descriptor `cfg_sel_i`. A write with `cfg_load_i`=0 unloads it. An access made in the same cycle as a write uses the descriptor as it was before that write.
- R8: `mem_req_o` and `fault_o` are never both high. When no response is pending, `mem_req_o`, `fault_o`, `paddr_o` and `fault_cause_o` are all zero.
- R9: The selector values 0 to 3 (code, stack, data, extra) address independent descriptors. Writing one descriptor leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Descriptor write strobe |
| cfg_sel_i | input | SEL_W | Descriptor to write |
| cfg_base_i | input | PA_W | Segment base address |
| cfg_size_i | input | OFF_W+1 | Segment size in address units |
| cfg_load_i | input | 1 | 1 loads the descriptor, 0 unloads it |
| req_i | input | 1 | Access request |
| sel_i | input | SEL_W | Segment selector of the access |
| off_i | input | OFF_W | Offset within the segment |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| paddr_o | output | PA_W | Physical address, zero on a fault |
| mem_req_o | output | 1 | Memory request strobe for a good access |
| fault_o | output | 1 | Access fault |
| fault_cause_o | output | 2 | 0 none, 1 unloaded segment, 2 bound exceeded |

## Verification
The bench builds the unit with OFF_W=4, PA_W=6 and four segments. At that size every selector and offset pair can be swept exhaustively, and the expected result is computed from its own copy of the written descriptors. The 6-bit physical space lets a base near the top wrap modulo 64. The 5-bit size field can hold both the empty segment (size 0) and the full segment (size 16). Three rounds of descriptor contents are swept: after reset, after loading, and after reloading and unloading. A write and an access are also issued in the same cycle, to confirm that the access uses the old descriptor.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_UNLOADED = 2'd1,
    FLT_BOUND    = 2'd2
  } flt_cause_e;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
  parameter int SEG_COUNT = 4,
  parameter int SEL_W     = 2,
  parameter int PA_W      = 20,
  parameter int SZ_W      = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [PA_W-1:0]  wbase_i,
  input  logic [SZ_W-1:0]  wsize_i,
  input  logic             wload_i,
  input  logic [SEL_W-1:0] rsel_i,
  output logic [PA_W-1:0]  rbase_o,
  output logic [SZ_W-1:0]  rsize_o,
  output logic             rloaded_o
);
  localparam int SLOTS = 1 << SEL_W;

  logic [PA_W-1:0] base_q   [SLOTS];
  logic [SZ_W-1:0] size_q   [SLOTS];
  logic            loaded_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < SEG_COUNT) begin : g_real
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_q[g]   <= '0;
          size_q[g]   <= '0;
          loaded_q[g] <= 1'b0;
        end else if (we_i && wsel_i == SEL_W'(g)) begin
          base_q[g]   <= wbase_i;
          size_q[g]   <= wsize_i;
          loaded_q[g] <= wload_i;
        end
      end
    end else begin : g_absent
      // selectors past SEG_COUNT read as unloaded
      assign base_q[g]   = '0;
      assign size_q[g]   = '0;
      assign loaded_q[g] = 1'b0;
    end
  end

  assign rbase_o   = base_q[rsel_i];
  assign rsize_o   = size_q[rsel_i];
  assign rloaded_o = loaded_q[rsel_i];
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import seg_xlat_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int PA_W  = 20,
  parameter int SZ_W  = OFF_W + 1
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic             loaded_i,
  output logic [PA_W-1:0]  sum_o,
  output flt_cause_e       cause_o
);
  // bound checked on the offset, so carry out of the adder cannot mask a violation
  assign sum_o = base_i + PA_W'(off_i);

  always_comb begin
    if (!loaded_i)                        cause_o = FLT_UNLOADED;
    else if (SZ_W'(off_i) >= size_i)      cause_o = FLT_BOUND;
    else                                  cause_o = FLT_NONE;
  end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
#(
  parameter int SEG_COUNT = 4,
  parameter int OFF_W     = 16,
  parameter int PA_W      = 20,
  localparam int SEL_W    = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1,
  localparam int SZ_W     = OFF_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [PA_W-1:0]  cfg_base_i,
  input  logic [SZ_W-1:0]  cfg_size_i,
  input  logic             cfg_load_i,
  input  logic             req_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             mem_req_o,
  output logic             fault_o,
  output logic [1:0]       fault_cause_o
);
  logic [PA_W-1:0] sel_base;
  logic [SZ_W-1:0] sel_size;
  logic            sel_loaded;
  logic [PA_W-1:0] sum;
  flt_cause_e      cause;

  seg_desc_table #(
    .SEG_COUNT(SEG_COUNT), .SEL_W(SEL_W), .PA_W(PA_W), .SZ_W(SZ_W)
  ) i_table (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .wsel_i(cfg_sel_i), .wbase_i(cfg_base_i),
    .wsize_i(cfg_size_i), .wload_i(cfg_load_i),
    .rsel_i(sel_i), .rbase_o(sel_base), .rsize_o(sel_size), .rloaded_o(sel_loaded)
  );

  seg_limit_check #(.OFF_W(OFF_W), .PA_W(PA_W), .SZ_W(SZ_W)) i_check (
    .off_i, .base_i(sel_base), .size_i(sel_size), .loaded_i(sel_loaded),
    .sum_o(sum), .cause_o(cause)
  );

  logic            rsp_valid_q, mem_req_q, fault_q;
  logic [PA_W-1:0] paddr_q;
  flt_cause_e      cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      mem_req_q   <= 1'b0;
      fault_q     <= 1'b0;
      paddr_q     <= '0;
      cause_q     <= FLT_NONE;
    end else begin
      rsp_valid_q <= req_i;
      mem_req_q   <= req_i && (cause == FLT_NONE);
      fault_q     <= req_i && (cause != FLT_NONE);
      paddr_q     <= (req_i && cause == FLT_NONE) ? sum : '0;
      cause_q     <= req_i ? cause : FLT_NONE;
    end
  end

  assign rsp_valid_o   = rsp_valid_q;
  assign mem_req_o     = mem_req_q;
  assign fault_o       = fault_q;
  assign paddr_o       = paddr_q;
  assign fault_cause_o = cause_q;

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o) else $error("rsp missing");  // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o) else $error("spurious rsp");  // R2
  AST_STROBE_XOR_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (mem_req_o ^ fault_o)) else $error("strobe/fault clash");  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!mem_req_o && !fault_o && paddr_o == '0)) else $error("idle not quiet");  // R8
  AST_PADDR_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && sel_loaded && (SZ_W'(off_i) < sel_size) |=>
      (mem_req_o && paddr_o == PA_W'($past(sel_base) + PA_W'($past(off_i)))))
    else $error("bad paddr");  // R3
  AST_BOUND_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && sel_loaded && (SZ_W'(off_i) >= sel_size) |=>
      (fault_o && !mem_req_o && fault_cause_o == 2'd2)) else $error("bound not caught");  // R4
  AST_UNLOADED_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !sel_loaded |=> (fault_o && fault_cause_o == 2'd1)) else $error("unloaded not caught");  // R5
endmodule

// File: tb/test_seg_xlat.sv
module test_seg_xlat;
  localparam int SEG_COUNT = 4;
  localparam int OFF_W     = 4;
  localparam int PA_W      = 6;
  localparam int SEL_W     = 2;
  localparam int SZ_W      = OFF_W + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [SEL_W-1:0] cfg_sel = '0;
  logic [PA_W-1:0]  cfg_base = '0;
  logic [SZ_W-1:0]  cfg_size = '0;
  logic             cfg_load = 1'b0;
  logic             req = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic [OFF_W-1:0] off = '0;
  logic             rsp_valid, mem_req, fault;
  logic [PA_W-1:0]  paddr;
  logic [1:0]       cause;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int m_base  [SEG_COUNT];
  int m_size  [SEG_COUNT];
  bit m_load  [SEG_COUNT];

  always #10 clk = ~clk;

  seg_xlat #(.SEG_COUNT(SEG_COUNT), .OFF_W(OFF_W), .PA_W(PA_W)) i_seg_xlat (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_base_i(cfg_base),
    .cfg_size_i(cfg_size), .cfg_load_i(cfg_load),
    .req_i(req), .sel_i(sel), .off_i(off),
    .rsp_valid_o(rsp_valid), .paddr_o(paddr), .mem_req_o(mem_req),
    .fault_o(fault), .fault_cause_o(cause)
  );

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int s, input int b, input int sz, input bit ld);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = SEL_W'(s); cfg_base = PA_W'(b);
    cfg_size = SZ_W'(sz); cfg_load = ld;
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[s] = b; m_size[s] = sz; m_load[s] = ld;
  endtask

  // packed response: {rsp_valid, mem_req, fault, cause[1:0], paddr[5:0]}
  function automatic logic [15:0] expect_rsp(input int s, input int o);
    if (!m_load[s])        return {5'b0, 1'b1, 1'b0, 1'b1, 2'd1, 6'd0};
    if (o >= m_size[s])    return {5'b0, 1'b1, 1'b0, 1'b1, 2'd2, 6'd0};
    return {5'b0, 1'b1, 1'b1, 1'b0, 2'd0, 6'((m_base[s] + o) % 64)};
  endfunction

  function automatic string tag_for(input int s, input int o);
    if (!m_load[s]) return "R5 unloaded";
    if (m_size[s] == 0 || m_size[s] == 16) return "R6 size edge";
    if (o >= m_size[s]) return "R4 bound";
    return "R3 translate";
  endfunction

  task automatic access(input int s, input int o, input string tag);
    logic [15:0] exp;
    exp = expect_rsp(s, o);
    @(negedge clk);
    req = 1'b1; sel = SEL_W'(s); off = OFF_W'(o);
    @(negedge clk);
    req = 1'b0;
    cmp(tag, {5'b0, rsp_valid, mem_req, fault, cause, paddr}, exp);
  endtask

  task automatic sweep(input string phase);
    for (int s = 0; s < SEG_COUNT; s++)
      for (int o = 0; o < 16; o++)
        access(s, o, $sformatf("%s %s sel%0d off%0d", tag_for(s, o), phase, s, o));
  endtask

  initial begin
    for (int s = 0; s < SEG_COUNT; s++) begin
      m_base[s] = 0; m_size[s] = 0; m_load[s] = 1'b0;
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs quiet after reset
    cmp("R1 reset outputs", {13'b0, rsp_valid, mem_req, fault}, 16'd0);
    // R1: every descriptor unloaded
    sweep("R1 post-reset");
    // R8: idle cycle after a response
    @(negedge clk);
    cmp("R8 idle quiet", {8'b0, rsp_valid, mem_req, fault, cause, 3'b0}, 16'd0);
    cmp("R8 idle paddr", {10'b0, paddr}, 16'd0);

    cfg_write(0, 0, 16, 1'b1);   // full segment
    cfg_write(1, 60, 5, 1'b1);   // wraps physical space
    cfg_write(2, 10, 0, 1'b1);   // empty segment
    cfg_write(3, 33, 9, 1'b0);   // written but unloaded
    sweep("R7 loaded");

    cfg_write(3, 20, 12, 1'b1);
    cfg_write(1, 5, 7, 1'b0);
    // R9: neighbours untouched by writes to seg 1 and 3
    access(0, 15, "R9 seg0 intact");
    access(2, 0, "R9 seg2 intact");
    sweep("R7 reloaded");

    // R7: same-cycle write and access sees the old descriptor (seg2 size 0)
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_base = 6'd40; cfg_size = 5'd8; cfg_load = 1'b1;
    req = 1'b1; sel = 2'd2; off = 4'd3;
    @(negedge clk);
    cfg_we = 1'b0; req = 1'b0;
    cmp("R7 same-cycle old", {5'b0, rsp_valid, mem_req, fault, cause, paddr},
        {5'b0, 1'b1, 1'b0, 1'b1, 2'd2, 6'd0});
    m_base[2] = 40; m_size[2] = 8; m_load[2] = 1'b1;
    access(2, 3, "R7 after write");
    access(2, 8, "R4 bound after write");

    // R2: back-to-back requests each get a response
    @(negedge clk);
    req = 1'b1; sel = 2'd3; off = 4'd1;
    @(negedge clk);
    off = 4'd2;
    cmp("R2 b2b first", {10'b0, rsp_valid, mem_req, paddr[3:0]}, {10'b0, 1'b1, 1'b1, 4'(21)});
    @(negedge clk);
    req = 1'b0;
    cmp("R2 b2b second", {10'b0, rsp_valid, mem_req, paddr[3:0]}, {10'b0, 1'b1, 1'b1, 4'(22)});
    @(negedge clk);
    cmp("R2 no rsp", {15'b0, rsp_valid}, 16'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule